// File: doc/BRIEF.md
# Virtual Address Region Decoder

The decoder sorts every 32-bit virtual address issued by a load, a store, an instruction fetch or a store-queue flush into one of four outcomes. The address can go out untouched, or with its three region bits cleared to form a 29-bit physical address. It can be forwarded for TLB translation, together with a flag that says whether the lookup must compare the address-space identifier. The fourth outcome is an address error, coded as a read fault or a write fault. The decision depends on the access kind, the privilege level and three configuration bits: translation enable, single-virtual mode, and a bit that blocks user access to the store-queue window.

A requester presents one access per transfer with a valid/ready handshake. The result comes back through a single registered output stage. That stage holds its value while the consumer stalls, and it can take a new request in the same cycle that the held result drains. For a store-queue flush with translation off, the decoder also forms the flush target from one of two 8-bit base values. Address bit 5 selects which base is used.

Top module: `vaddr_region_dec`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: A privileged load (in_kind 0) or store (in_kind 1) at 0xE0000000 or above gives out_class 0 (unchanged) with out_addr equal to in_addr.
- R3: A privileged load or store from 0x80000000 to 0xBFFFFFFF gives out_class 1 (stripped) with out_addr = in_addr AND 0x1FFFFFFF.
- R4: A user load or store with bit 31 set gives out_class 0 with out_addr = in_addr only when the address is in 0xE0000000..0xE3FFFFFF and cfg_sqmd is 0. Any other such access gives out_class 3 with out_addr = in_addr. Its out_fault is 1 for a load and 2 for a store. Every result that is not out_class 3 carries out_fault 0.
- R5: With cfg_at 0, any access not settled by R2, R3, R4, R7 or R8 gives out_class 1 with out_addr = in_addr AND 0x1FFFFFFF. This covers privileged data in 0xC0000000..0xDFFFFFFF and every address with bit 31 clear.
- R6: With cfg_at 1, the same accesses give out_class 2 (translate) with out_addr = in_addr. out_asid_chk is 1 when cfg_sv is 0 or the access is from user mode, and 0 otherwise. Outcomes other than class 2 carry out_asid_chk 0.
- R7: A privileged fetch (in_kind 2) from 0x80000000 to 0xBFFFFFFF is stripped as in R3. A privileged fetch from 0xE0000000 to 0xFFFFFEFF gives out_class 3 with out_fault 1. A privileged fetch from 0xC0000000 to 0xDFFFFFFF, or from 0xFFFFFF00 up, follows R5/R6.
- R8: A user fetch with bit 31 set gives out_class 3, out_fault 1 and out_addr = in_addr, whatever cfg_sqmd is.
- R9: A store-queue flush (in_kind 3) with cfg_at 0 gives out_class 1 with out_addr = (in_addr AND 0x03FFFFE0) OR (base << 24). The base is sq_base1 when in_addr bit 5 is 1 and sq_base0 when it is 0. With cfg_at 1 the flush follows R6.
- R10: A request is taken when in_valid and in_ready are both 1. Its result is presented one cycle later, and results leave in request order. in_ready is 0 exactly while a result waits with out_ready 0, and during that wait every output stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Decoder can take the request |
| in_addr | input | 32 | Virtual address |
| in_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 store-queue flush |
| in_priv | input | 1 | 1 = privileged mode |
| cfg_at | input | 1 | Translation enable |
| cfg_sv | input | 1 | Single-virtual mode |
| cfg_sqmd | input | 1 | Block user access to the store-queue window |
| sq_base0 | input | 8 | Flush target high byte when address bit 5 is 0 |
| sq_base1 | input | 8 | Flush target high byte when address bit 5 is 1 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 2 | 0 unchanged, 1 stripped, 2 translate, 3 fault |
| out_addr | output | 32 | Physical, translate or faulting address |
| out_asid_chk | output | 1 | Translate lookup compares the identifier |
| out_fault | output | 2 | 0 none, 1 read address error, 2 write address error |

## Verification
Two things can fall in the same cycle: the output register draining a held result and the same register loading the next request. This happens when out_ready rises while in_valid is already waiting. The bench drives requests back to back and holds out_ready low on a pseudo-random pattern, so the drain-and-refill case occurs many times among the stalls. A scoreboard judges it: every result must arrive in request order, with class, address, identifier flag and fault all equal to the expected values.

// File: rtl/vrd_pkg.sv
`timescale 1ns/1ps
package vrd_pkg;

  localparam int unsigned VA_W   = 32;
  localparam int unsigned QB_W   = 8;
  localparam int unsigned QB_SH  = VA_W - QB_W;

  typedef logic [VA_W-1:0] va_t;
  typedef logic [QB_W-1:0] qbase_t;

  typedef enum logic [1:0] {
    ACC_LOAD    = 2'd0,
    ACC_STORE   = 2'd1,
    ACC_FETCH   = 2'd2,
    ACC_SQFLUSH = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    OUT_RAW   = 2'd0,
    OUT_STRIP = 2'd1,
    OUT_XLAT  = 2'd2,
    OUT_FAULT = 2'd3
  } outc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_RD   = 2'd1,
    FLT_WR   = 2'd2
  } flt_e;

  typedef struct packed {
    outc_e outc;
    va_t   addr;
    logic  asid_chk;
    flt_e  flt;
  } res_t;

  localparam va_t STRIP_MASK  = 32'h1FFF_FFFF;
  localparam va_t P3_BASE     = 32'hC000_0000;
  localparam va_t P4_BASE     = 32'hE000_0000;
  localparam va_t SQ_LIMIT    = 32'hE400_0000;
  localparam va_t FETCH_LIMIT = 32'hFFFF_FF00;
  localparam va_t SQ_OFS_MASK = 32'h03FF_FFE0;
  localparam int unsigned SQ_SEL_BIT = 5;

  function automatic va_t f_strip(input va_t a);
    return a & STRIP_MASK;
  endfunction

  function automatic logic f_upper(input va_t a);
    return a[VA_W-1];
  endfunction

  function automatic logic f_below_p3(input va_t a);
    return a < P3_BASE;
  endfunction

  function automatic logic f_in_p4(input va_t a);
    return a >= P4_BASE;
  endfunction

  function automatic logic f_sq_window(input va_t a);
    return (a >= P4_BASE) && (a < SQ_LIMIT);
  endfunction

  function automatic logic f_fetch_hole(input va_t a);
    return (a >= P4_BASE) && (a < FETCH_LIMIT);
  endfunction

  // identifier compared unless single-virtual and privileged
  function automatic logic f_asid_rule(input logic sv, input logic priv);
    return !sv || !priv;
  endfunction

  function automatic va_t f_sq_target(input va_t a, input qbase_t b0, input qbase_t b1);
    qbase_t b;
    b = a[SQ_SEL_BIT] ? b1 : b0;
    return (a & SQ_OFS_MASK) | (va_t'(b) << QB_SH);
  endfunction

  function automatic res_t f_mk(input outc_e o, input va_t a, input logic chk, input flt_e f);
    res_t r;
    r.outc     = o;
    r.addr     = a;
    r.asid_chk = chk;
    r.flt      = f;
    return r;
  endfunction

  // common tail: translate when enabled, else strip to 29 bits
  function automatic res_t f_tail(input va_t a, input logic at, input logic chk);
    if (at) return f_mk(OUT_XLAT, a, chk, FLT_NONE);
    return f_mk(OUT_STRIP, f_strip(a), 1'b0, FLT_NONE);
  endfunction

endpackage

// File: rtl/vrd_data_rules.sv
`timescale 1ns/1ps
module vrd_data_rules
  import vrd_pkg::*;
(
  input  va_t  addr,
  input  logic is_store,
  input  logic priv,
  input  logic at,
  input  logic sv,
  input  logic sqmd,
  output res_t res
);

  logic hi_priv_p4;
  logic hi_priv_p12;
  logic hi_user;
  logic user_sq_ok;

  assign hi_priv_p4  = f_upper(addr) && priv && f_in_p4(addr);
  assign hi_priv_p12 = f_upper(addr) && priv && f_below_p3(addr);
  assign hi_user     = f_upper(addr) && !priv;
  assign user_sq_ok  = f_sq_window(addr) && !sqmd;

  always_comb begin
    if (hi_priv_p4) begin
      res = f_mk(OUT_RAW, addr, 1'b0, FLT_NONE);
    end else if (hi_priv_p12) begin
      res = f_mk(OUT_STRIP, f_strip(addr), 1'b0, FLT_NONE);
    end else if (hi_user) begin
      if (user_sq_ok) res = f_mk(OUT_RAW, addr, 1'b0, FLT_NONE);
      else            res = f_mk(OUT_FAULT, addr, 1'b0, is_store ? FLT_WR : FLT_RD);
    end else begin
      res = f_tail(addr, at, f_asid_rule(sv, priv));
    end
  end

endmodule

// File: rtl/vrd_fetch_rules.sv
`timescale 1ns/1ps
module vrd_fetch_rules
  import vrd_pkg::*;
(
  input  va_t  addr,
  input  logic priv,
  input  logic at,
  input  logic sv,
  output res_t res
);

  logic p_strip;
  logic p_hole;
  logic u_high;

  assign p_strip = priv && f_upper(addr) && f_below_p3(addr);
  assign p_hole  = priv && f_fetch_hole(addr);
  assign u_high  = !priv && f_upper(addr);

  always_comb begin
    if (p_strip) begin
      res = f_mk(OUT_STRIP, f_strip(addr), 1'b0, FLT_NONE);
    end else if (p_hole || u_high) begin
      res = f_mk(OUT_FAULT, addr, 1'b0, FLT_RD);
    end else begin
      res = f_tail(addr, at, f_asid_rule(sv, priv));
    end
  end

endmodule

// File: rtl/vrd_sq_rules.sv
`timescale 1ns/1ps
module vrd_sq_rules
  import vrd_pkg::*;
(
  input  va_t    addr,
  input  logic   priv,
  input  logic   at,
  input  logic   sv,
  input  qbase_t base0,
  input  qbase_t base1,
  output res_t   res
);

  va_t target;
  assign target = f_sq_target(addr, base0, base1);

  always_comb begin
    if (at) res = f_mk(OUT_XLAT, addr, f_asid_rule(sv, priv), FLT_NONE);
    else    res = f_mk(OUT_STRIP, target, 1'b0, FLT_NONE);
  end

endmodule

// File: rtl/vrd_out_stage.sv
`timescale 1ns/1ps
module vrd_out_stage
  import vrd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_valid,
  output logic up_ready,
  input  res_t up_data,
  output logic dn_valid,
  input  logic dn_ready,
  output res_t dn_data
);

  logic valid_q;
  res_t data_q;

  assign up_ready = !valid_q || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (up_ready) begin
      valid_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  assign dn_valid = valid_q;
  assign dn_data  = data_q;

endmodule

// File: rtl/vaddr_region_dec.sv
`timescale 1ns/1ps
module vaddr_region_dec
  import vrd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_addr,
  input  logic [1:0]  in_kind,
  input  logic        in_priv,
  input  logic        cfg_at,
  input  logic        cfg_sv,
  input  logic        cfg_sqmd,
  input  logic [7:0]  sq_base0,
  input  logic [7:0]  sq_base1,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_class,
  output logic [31:0] out_addr,
  output logic        out_asid_chk,
  output logic [1:0]  out_fault
);

  res_t r_data;
  res_t r_fetch;
  res_t r_sq;
  res_t r_sel;
  res_t r_out;
  logic accept;

  vrd_data_rules u_data (
    .addr     (in_addr),
    .is_store (in_kind == ACC_STORE),
    .priv     (in_priv),
    .at       (cfg_at),
    .sv       (cfg_sv),
    .sqmd     (cfg_sqmd),
    .res      (r_data)
  );

  vrd_fetch_rules u_fetch (
    .addr (in_addr),
    .priv (in_priv),
    .at   (cfg_at),
    .sv   (cfg_sv),
    .res  (r_fetch)
  );

  vrd_sq_rules u_sq (
    .addr  (in_addr),
    .priv  (in_priv),
    .at    (cfg_at),
    .sv    (cfg_sv),
    .base0 (sq_base0),
    .base1 (sq_base1),
    .res   (r_sq)
  );

  always_comb begin
    case (acc_e'(in_kind))
      ACC_FETCH:   r_sel = r_fetch;
      ACC_SQFLUSH: r_sel = r_sq;
      default:     r_sel = r_data;
    endcase
  end

  vrd_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (r_sel),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (r_out)
  );

  assign accept       = in_valid && in_ready;
  assign out_class    = r_out.outc;
  assign out_addr     = r_out.addr;
  assign out_asid_chk = r_out.asid_chk;
  assign out_fault    = r_out.flt;

endmodule

// File: rtl/vaddr_region_dec_chk.sv
`timescale 1ns/1ps
module vaddr_region_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic [31:0] in_addr,
  input logic [1:0]  in_kind,
  input logic        in_priv,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_class,
  input logic [31:0] out_addr,
  input logic        out_asid_chk,
  input logic [1:0]  out_fault
);

  // R10: a stalled result stays put
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_class)
                                && $stable(out_fault) && $stable(out_asid_chk));

  // R10: a taken request shows up on the next cycle
  a_r10_fill: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R4: fault code present exactly on fault results
  a_r4_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_class == 2'd3) == (out_fault != 2'd0)));

  // R8: user fetch with bit 31 set is a read fault
  a_r8_user_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(accept) && $past(in_kind) == 2'd2 && !$past(in_priv) && $past(in_addr[31])
    |-> out_class == 2'd3 && out_fault == 2'd1 && out_addr == $past(in_addr));

  // R3: stripped data results have empty region bits
  a_r3_strip_region: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(accept) && $past(in_kind) != 2'd3 && out_class == 2'd1
    |-> out_addr[31:29] == 3'b000);

  // R2: unchanged results equal the request address
  a_r2_raw_equal: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(accept) && out_class == 2'd0 |-> out_addr == $past(in_addr));

  // R6: user translations always compare the identifier
  a_r6_user_asid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(accept) && !$past(in_priv) && out_class == 2'd2 |-> out_asid_chk);

endmodule

bind vaddr_region_dec vaddr_region_dec_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .in_addr      (in_addr),
  .in_kind      (in_kind),
  .in_priv      (in_priv),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_class    (out_class),
  .out_addr     (out_addr),
  .out_asid_chk (out_asid_chk),
  .out_fault    (out_fault)
);

// File: tb/vaddr_region_dec_tb.sv
`timescale 1ns/1ps
module vaddr_region_dec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_kind = '0;
  logic        in_priv = 1'b0;
  logic        cfg_at = 1'b0;
  logic        cfg_sv = 1'b0;
  logic        cfg_sqmd = 1'b0;
  logic [7:0]  sq_base0 = 8'hA5;
  logic [7:0]  sq_base1 = 8'h3C;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_class;
  logic [31:0] out_addr;
  logic        out_asid_chk;
  logic [1:0]  out_fault;

  always #4 clk = ~clk;

  vaddr_region_dec u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_kind(in_kind), .in_priv(in_priv),
    .cfg_at(cfg_at), .cfg_sv(cfg_sv), .cfg_sqmd(cfg_sqmd),
    .sq_base0(sq_base0), .sq_base1(sq_base1),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_addr(out_addr), .out_asid_chk(out_asid_chk), .out_fault(out_fault)
  );

  typedef struct {
    logic [1:0]  cls;
    logic [31:0] addr;
    logic        chk;
    logic [1:0]  flt;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   stall_mode = 1'b0;
  bit   finished = 1'b0;

  function automatic exp_t mk(input logic [1:0] c, input logic [31:0] a,
                              input logic k, input logic [1:0] f, input string t);
    exp_t e;
    e.cls = c; e.addr = a; e.chk = k; e.flt = f; e.tag = t;
    return e;
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic [1:0] k,
                                   input logic p, input logic at);
    if (k == 2'd3) return "R9";
    if (k == 2'd2 && a[31]) return p ? "R7" : "R8";
    if (k != 2'd2 && a[31] && !p) return "R4";
    if (k != 2'd2 && a[31] && p && a[31:29] == 3'b111) return "R2";
    if (k != 2'd2 && a[31] && p && a[31:30] == 2'b10) return "R3";
    return at ? "R6" : "R5";
  endfunction

  // expected outcome written from the requirement text
  function automatic exp_t model(input logic [31:0] a, input logic [1:0] k, input logic p,
                                 input logic at, input logic sv, input logic sqmd);
    string t;
    logic [2:0] rg;
    logic [31:0] tgt;
    t  = tag_of(a, k, p, at);
    rg = a[31:29];
    if (k == 2'd3) begin
      tgt = {(a[5] ? sq_base1 : sq_base0), 24'h0} | {6'b0, a[25:5], 5'b0};
      if (!at) return mk(2'd1, tgt, 1'b0, 2'd0, t);
      return mk(2'd2, a, !(sv && p), 2'd0, t);
    end
    if (k == 2'd2 && a[31]) begin
      if (!p) return mk(2'd3, a, 1'b0, 2'd1, t);
      if (rg == 3'd4 || rg == 3'd5) return mk(2'd1, {3'b0, a[28:0]}, 1'b0, 2'd0, t);
      if (rg == 3'd7 && a[31:8] != 24'hFFFFFF) return mk(2'd3, a, 1'b0, 2'd1, t);
    end
    if (k != 2'd2 && a[31]) begin
      if (p && rg == 3'd7) return mk(2'd0, a, 1'b0, 2'd0, t);
      if (p && (rg == 3'd4 || rg == 3'd5)) return mk(2'd1, {3'b0, a[28:0]}, 1'b0, 2'd0, t);
      if (!p) begin
        if (a[31:26] == 6'b111000 && !sqmd) return mk(2'd0, a, 1'b0, 2'd0, t);
        return mk(2'd3, a, 1'b0, (k == 2'd1) ? 2'd2 : 2'd1, t);
      end
    end
    if (!at) return mk(2'd1, {3'b0, a[28:0]}, 1'b0, 2'd0, t);
    return mk(2'd2, a, !(sv && p), 2'd0, t);
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [1:0] k, input logic p,
                       input logic at, input logic sv, input logic sqmd);
    bit took;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_kind = k; in_priv = p;
    cfg_at = at; cfg_sv = sv; cfg_sqmd = sqmd;
    took = 1'b0;
    while (!took) begin
      #3;
      took = in_ready;
      if (took) sb.push_back(model(a, k, p, at, sv, sqmd));
      @(posedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  // consumer readiness, changed away from both edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor: compares each result as it leaves
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (!out_ready) begin
          note(in_ready == 1'b0, "R10", "in_ready during stall", 64'(in_ready), 64'd0);
        end else if (sb.size() == 0) begin
          note(1'b0, "R10", "result without request", 64'(out_addr), 64'd0);
        end else begin
          e = sb.pop_front();
          note(out_class == e.cls && out_addr == e.addr && out_asid_chk == e.chk
               && out_fault == e.flt, e.tag, "class/addr/chk/fault",
               {29'd0, out_class, out_fault, out_asid_chk, out_addr},
               {29'd0, e.cls, e.flt, e.chk, e.addr});
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, pending=%0d", sb.size());
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [1:0]  k;
    repeat (3) @(negedge clk);
    note(out_valid == 1'b0 && in_ready == 1'b1, "R1", "in reset valid/ready",
         {out_valid, in_ready}, 64'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after reset valid/ready",
         {out_valid, in_ready}, 64'b01);

    // R2 / R3 privileged data
    drive(32'hE000_0000, 2'd0, 1, 1, 0, 0);
    drive(32'hFFFF_FFFC, 2'd1, 1, 0, 0, 0);
    drive(32'h8000_0000, 2'd0, 1, 1, 0, 0);
    drive(32'hBFFF_FFFF, 2'd1, 1, 1, 1, 0);
    // R5 / R6 privileged P3 and low half
    drive(32'hC000_0000, 2'd0, 1, 0, 0, 0);
    drive(32'hDFFF_FFFF, 2'd1, 1, 1, 1, 0);
    drive(32'hDFFF_FFFF, 2'd1, 1, 1, 0, 0);
    drive(32'h7FFF_FFFF, 2'd0, 0, 1, 1, 0);
    drive(32'h1234_5678, 2'd1, 1, 0, 1, 0);
    // R4 user window and faults
    drive(32'hE000_0000, 2'd0, 0, 1, 0, 0);
    drive(32'hE3FF_FFFF, 2'd1, 0, 1, 0, 0);
    drive(32'hE3FF_FFFF, 2'd1, 0, 1, 0, 1);
    drive(32'hE400_0000, 2'd0, 0, 1, 0, 0);
    drive(32'h8000_0000, 2'd1, 0, 0, 0, 0);
    // R7 / R8 fetch
    drive(32'hA000_0100, 2'd2, 1, 1, 0, 0);
    drive(32'hE000_0000, 2'd2, 1, 1, 0, 0);
    drive(32'hFFFF_FEFF, 2'd2, 1, 1, 0, 0);
    drive(32'hFFFF_FF00, 2'd2, 1, 1, 1, 0);
    drive(32'hFFFF_FF00, 2'd2, 1, 0, 1, 0);
    drive(32'hC000_0040, 2'd2, 1, 1, 0, 0);
    drive(32'hE000_0000, 2'd2, 0, 1, 0, 0);
    drive(32'h0000_1000, 2'd2, 0, 1, 1, 0);
    // R9 store-queue flush, both bases
    drive(32'hE123_4560, 2'd3, 1, 0, 0, 0);
    drive(32'hE123_4540, 2'd3, 1, 0, 0, 0);
    drive(32'hE3FF_FFFF, 2'd3, 0, 0, 0, 0);
    drive(32'hE000_0020, 2'd3, 1, 1, 1, 0);
    drive(32'hE000_0020, 2'd3, 0, 1, 1, 0);

    // R10 back to back under consumer stalls, mixed patterns
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      a = $urandom;
      case ($urandom % 6)
        0: a[31:26] = 6'b111000;
        1: a[31:8]  = 24'hFFFFFF;
        2: a[31:29] = 3'd6;
        default: ;
      endcase
      k = 2'($urandom % 4);
      drive(a, k, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    stall_mode = 1'b0;

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    note(out_valid == 1'b0, "R10", "idle after drain", 64'(out_valid), 64'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule